// File: doc/BRIEF.md
# GPIO Interrupt Routing Multiplexer

This block takes a wide bus of asynchronous pad signals and delivers any eight of them to eight interrupt channels for a downstream interrupt controller. Every pad is brought into the clock domain by a two-stage synchroniser. Each channel then picks one synchronised pad by an 8-bit index. It can invert that pad, pass it through a programmable glitch filter, and present it either as a level or as a one-clock pulse. The polarity conversion means that active-low and falling-edge sources still appear downstream as active-high levels or rising pulses.

Configuration lives in four 32-bit words behind a simple bus. The bus has a select strobe, a write flag, a byte address and write data. Read data is combinational and reflects the addressed word. Each channel's glitch filter is a two-state machine with two states. In FLT_HOLD the filtered value agrees with the input. In FLT_PEND a disagreement is being timed. The filter has four transitions:
- HOLD_COMMIT stays in FLT_HOLD and copies the input at once when the limit is 0 or 1.
- HOLD_TO_PEND starts timing a disagreement when the limit is 2 or more.
- PEND_DROP returns to FLT_HOLD when the input agrees again before the limit is reached.
- PEND_COMMIT copies the input and returns to FLT_HOLD once the disagreement has lasted limit cycles.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, all four configuration words read as zero and every channel output is low. In that state each channel selects pad 0, in level mode, with no inversion and no filtering.
- R2: Word-aligned offset 0x04 holds the pad indices for channels 0 to 3, and offset 0x08 holds them for channels 4 to 7. The index for channel c sits at bits (c mod 4)*8+7 : (c mod 4)*8. A written word reads back unchanged.
- R3: Offset 0x00 is the mode word. Bit c selects pulse (edge) mode for channel c, and bit 16+c inverts channel c. Bits 15:8 and 31:24 always read as zero and ignore writes.
- R4: Offset 0x0C holds a 4-bit filter limit for channel c at bits c*4+3 : c*4. A written word reads back unchanged.
- R5: In level mode without inversion, the output follows the selected pad. A pad change with filter limit 0 first appears after the fourth rising clock edge that follows it.
- R6: With inversion set in level mode, the output is high while the selected pad is low and low while the pad is high.
- R7: In edge mode without inversion, a rising pad gives an output high for exactly one clock, after the fourth edge. A falling pad gives no pulse.
- R8: In edge mode with inversion, a falling pad gives exactly one one-clock pulse and a rising pad gives none.
- R9: With filter limit N of 2 or more, a pad pulse shorter than N cycles never reaches the output. A pad change held for N cycles reaches a level-mode output after edge 3+N and not before. Limits 0 and 1 give the unfiltered latency.
- R10: An index equal to or above the pad count selects a constant 0 before inversion. Such a channel is therefore low without inversion and high with inversion, whatever the pads do.
- R11: Channels are independent. Two channels that select the same pad in different modes respond in the same cycle, each according to its own mode and inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pads | input | NUM_PADS | Asynchronous pad inputs |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the configuration word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| irq_out | output | 8 | Active-high channel outputs |

## Verification
Pulse detection on one channel and inverted level tracking on another can resolve in the same cycle when both channels select one pad. The bench routes a single pad to a rising-edge channel and to an inverted level channel, then raises that pad. At the sample after the fourth edge it requires the pulse channel to be high and the inverted channel to be low together, and in the next cycle it requires both to be low. A missed pulse, a late pulse, or a cross-coupling between the channels shows up as a wrong two-bit pattern.

// File: rtl/gpio_route_pkg.sv
package gpio_route_pkg;
    localparam int CHANNELS = 8;
    localparam int SEL_W    = 8;
    localparam int FLT_W    = 4;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int INV_BASE = 16;
    localparam int SEL_SPAN = 2 ** SEL_W;

    localparam logic [1:0] WRD_MODE   = 2'd0;
    localparam logic [1:0] WRD_SEL_LO = 2'd1;
    localparam logic [1:0] WRD_SEL_HI = 2'd2;
    localparam logic [1:0] WRD_FILT   = 2'd3;

    typedef enum logic {
        FLT_HOLD = 1'b0,
        FLT_PEND = 1'b1
    } flt_state_t;
endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
    parameter int WIDTH = 110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sync_out == $past(stage1_q)); // R5
endmodule

// File: rtl/route_regs.sv
module route_regs
    import gpio_route_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [CHANNELS-1:0]       edge_en,
    output logic [CHANNELS-1:0]       inv_en,
    output logic [CHANNELS*SEL_W-1:0] sel_flat,
    output logic [CHANNELS*FLT_W-1:0] flt_flat
);
    localparam int HALF = CHANNELS / 2;

    logic [CHANNELS-1:0] edge_q;
    logic [CHANNELS-1:0] inv_q;
    logic [DATA_W-1:0]   sel_lo_q;
    logic [DATA_W-1:0]   sel_hi_q;
    logic [DATA_W-1:0]   filt_q;
    logic                aligned;
    logic                wr_hit;
    logic [1:0]          word;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign word    = bus_addr[3:2];
    assign wr_hit  = bus_sel && bus_wr && aligned;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q   <= '0;
            inv_q    <= '0;
            sel_lo_q <= '0;
            sel_hi_q <= '0;
            filt_q   <= '0;
        end else if (wr_hit) begin
            unique case (word)
                WRD_MODE: begin
                    edge_q <= bus_wdata[CHANNELS-1:0];
                    inv_q  <= bus_wdata[INV_BASE +: CHANNELS];
                end
                WRD_SEL_LO: sel_lo_q <= bus_wdata;
                WRD_SEL_HI: sel_hi_q <= bus_wdata;
                WRD_FILT:   filt_q   <= bus_wdata;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && aligned) begin
            unique case (word)
                WRD_MODE: begin
                    bus_rdata[CHANNELS-1:0]          = edge_q;
                    bus_rdata[INV_BASE +: CHANNELS]  = inv_q;
                end
                WRD_SEL_LO: bus_rdata = sel_lo_q;
                WRD_SEL_HI: bus_rdata = sel_hi_q;
                WRD_FILT:   bus_rdata = filt_q;
            endcase
        end
    end

    assign edge_en  = edge_q;
    assign inv_en   = inv_q;
    assign sel_flat = {sel_hi_q, sel_lo_q};
    assign flt_flat = filt_q;

    AST_SEL_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && word == WRD_SEL_LO) |=> sel_flat[HALF*SEL_W-1:0] == $past(bus_wdata)); // R2
    AST_MODE_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && aligned && word == WRD_MODE) |->
        (bus_rdata[15:8] == 8'h00 && bus_rdata[31:24] == 8'h00)); // R3
    AST_FILT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && word == WRD_FILT) |=> flt_flat == $past(bus_wdata)); // R4
endmodule

// File: rtl/chan_filter.sv
module chan_filter
    import gpio_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [FLT_W-1:0] limit,
    output logic             dout
);
    flt_state_t       state_q, state_d;
    logic [FLT_W-1:0] cnt_q, cnt_d;
    logic             filt_q, filt_d;
    logic             short_lim;

    assign short_lim = (limit <= FLT_W'(1));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        filt_d  = filt_q;
        unique case (state_q)
            FLT_HOLD: begin
                if (din != filt_q) begin
                    if (short_lim) begin
                        filt_d = din;                 // HOLD_COMMIT
                    end else begin
                        state_d = FLT_PEND;           // HOLD_TO_PEND
                        cnt_d   = FLT_W'(1);
                    end
                end
            end
            FLT_PEND: begin
                if (din == filt_q) begin
                    state_d = FLT_HOLD;               // PEND_DROP
                    cnt_d   = '0;
                end else if (short_lim || cnt_q >= limit - FLT_W'(1)) begin
                    state_d = FLT_HOLD;               // PEND_COMMIT
                    cnt_d   = '0;
                    filt_d  = din;
                end else begin
                    cnt_d = cnt_q + FLT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_HOLD;
            cnt_q   <= '0;
            filt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            filt_q  <= filt_d;
        end
    end

    always_comb begin
        dout = filt_q;
    end

    AST_FILT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(din) == filt_q)); // R9
    AST_FILT_AGREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (din == filt_q) |=> $stable(filt_q)); // R9
endmodule

// File: rtl/chan_edge.sv
module chan_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic filt,
    input  logic edge_mode,
    output logic irq
);
    logic prev_q;
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            prev_q <= filt;
            irq_q  <= edge_mode ? (filt & ~prev_q) : filt;
        end
    end

    assign irq = irq_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && edge_mode) |=> !irq); // R7
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |=> irq == $past(filt)); // R5
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpio_route_pkg::*;
#(
    parameter int NUM_PADS = 110
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pads,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [3:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [7:0]          irq_out
);
    logic [NUM_PADS-1:0]       pad_s;
    logic [SEL_SPAN-1:0]       pad_ext;
    logic [CHANNELS-1:0]       edge_en;
    logic [CHANNELS-1:0]       inv_en;
    logic [CHANNELS*SEL_W-1:0] sel_flat;
    logic [CHANNELS*FLT_W-1:0] flt_flat;

    pad_sync #(.WIDTH(NUM_PADS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pads),
        .sync_out (pad_s)
    );

    route_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .edge_en   (edge_en),
        .inv_en    (inv_en),
        .sel_flat  (sel_flat),
        .flt_flat  (flt_flat)
    );

    always_comb begin
        pad_ext = '0;
        pad_ext[NUM_PADS-1:0] = pad_s;
    end

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        logic [SEL_W-1:0] sel_c;
        logic             pick;
        logic             cond;
        logic             filt;

        assign sel_c = sel_flat[c*SEL_W +: SEL_W];
        assign pick  = pad_ext[sel_c];
        assign cond  = pick ^ inv_en[c];

        chan_filter u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (cond),
            .limit (flt_flat[c*FLT_W +: FLT_W]),
            .dout  (filt)
        );

        chan_edge u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .filt      (filt),
            .edge_mode (edge_en[c]),
            .irq       (irq_out[c])
        );

        AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(sel_c) >= NUM_PADS) |-> !pick); // R10
    end
endmodule

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 110;

    // vector fields: [10:3] pad index, [2] invert, [1] pad level, [0] expected ch0
    localparam logic [10:0] VEC [10] = '{
        {8'd5,   1'b0, 1'b1, 1'b1},
        {8'd5,   1'b0, 1'b0, 1'b0},
        {8'd5,   1'b1, 1'b0, 1'b1},
        {8'd5,   1'b1, 1'b1, 1'b0},
        {8'd109, 1'b0, 1'b1, 1'b1},
        {8'd109, 1'b1, 1'b1, 1'b0},
        {8'd110, 1'b0, 1'b1, 1'b0},
        {8'd255, 1'b0, 1'b0, 1'b0},
        {8'd200, 1'b1, 1'b1, 1'b1},
        {8'd200, 1'b1, 1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pads = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [7:0]    irq_out;

    int checks = 0;
    int fails = 0;

    gpio_irq_router #(.NUM_PADS(NP)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pads      (pads),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int highs;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        check("R1 irq after reset", {24'h0, irq_out}, 32'h0);
        for (int w = 0; w < 4; w++) begin
            rd(4'(w * 4), d);
            check("R1 word reset", d, 32'h0);
        end

        // R2/R3/R4 register layout
        wr(4'h4, 32'h44332211); rd(4'h4, d); check("R2 sel lo readback", d, 32'h44332211);
        wr(4'h8, 32'h88776655); rd(4'h8, d); check("R2 sel hi readback", d, 32'h88776655);
        wr(4'hC, 32'h87654321); rd(4'hC, d); check("R4 filter readback", d, 32'h87654321);
        wr(4'h0, 32'hFFFFFFFF); rd(4'h0, d); check("R3 mode reserved zero", d, 32'h00FF00FF);
        wr(4'h0, 32'h0); wr(4'h4, 32'h0); wr(4'h8, 32'h0); wr(4'hC, 32'h0);

        // Table walk: channel 0 level mode, R5 R6 R10
        for (int i = 0; i < 10; i++) begin
            logic [7:0] s;
            logic inv, lvl, ex;
            logic [NP-1:0] onehot;
            {s, inv, lvl, ex} = VEC[i];
            onehot = '0;
            if (int'(s) < NP) onehot[s] = 1'b1;
            pads = lvl ? onehot : ~onehot;
            wr(4'h4, {24'h0, s});
            wr(4'h0, {15'h0, inv, 16'h0});
            step(6);
            check($sformatf("R6 R10 vector %0d ch0", i), {31'h0, irq_out[0]}, {31'h0, ex});
        end

        // R5 latency, filter off
        wr(4'h0, 32'h0); wr(4'h4, 32'd30); pads = '0; step(6);
        pads[30] = 1'b1;
        step(3); check("R5 not before edge 4", {31'h0, irq_out[0]}, 32'h0);
        step(1); check("R5 at edge 4", {31'h0, irq_out[0]}, 32'h1);
        pads[30] = 1'b0; step(4); check("R5 follows low", {31'h0, irq_out[0]}, 32'h0);

        // R7 rising edge pulse on ch1, pad 7
        wr(4'h4, {16'h0, 8'd7, 8'd30}); wr(4'h0, 32'h2); step(6);
        pads[7] = 1'b1;
        step(4); check("R7 pulse high", {31'h0, irq_out[1]}, 32'h1);
        step(1); check("R7 pulse one cycle", {31'h0, irq_out[1]}, 32'h0);
        pads[7] = 1'b0; highs = 0;
        for (int k = 0; k < 8; k++) begin step(1); if (irq_out[1]) highs++; end
        check("R7 no pulse on fall", highs, 0);

        // R8 inverted edge on ch2, pad 9
        wr(4'h4, {8'h0, 8'd9, 8'd7, 8'd30}); wr(4'h0, 32'h0004_0004); step(8);
        pads[9] = 1'b1; highs = 0;
        for (int k = 0; k < 8; k++) begin step(1); if (irq_out[2]) highs++; end
        check("R8 no pulse on rise", highs, 0);
        pads[9] = 1'b0;
        step(4); check("R8 pulse on fall", {31'h0, irq_out[2]}, 32'h1);
        step(1); check("R8 pulse one cycle", {31'h0, irq_out[2]}, 32'h0);

        // R9 filter limit 3 on ch3 (bits 15:12), pad 11, level
        wr(4'h0, 32'h0); wr(4'h4, {8'd11, 8'd9, 8'd7, 8'd30}); wr(4'hC, 32'h0000_3000); step(8);
        pads[11] = 1'b1; step(2); pads[11] = 1'b0; highs = 0;
        for (int k = 0; k < 10; k++) begin step(1); if (irq_out[3]) highs++; end
        check("R9 glitch suppressed", highs, 0);
        pads[11] = 1'b1;
        step(5); check("R9 not before edge 3+N", {31'h0, irq_out[3]}, 32'h0);
        step(1); check("R9 at edge 3+N", {31'h0, irq_out[3]}, 32'h1);
        check("R4 other channels unfiltered", {31'h0, irq_out[0]}, 32'h0);

        // R11 ch4 rising edge and ch5 inverted level on pad 20
        pads = '0;
        wr(4'h8, {16'h0, 8'd20, 8'd20}); wr(4'h0, 32'h0020_0010); wr(4'hC, 32'h0); step(8);
        check("R11 inverted idle high", {30'h0, irq_out[5:4]}, 32'h2);
        pads[20] = 1'b1;
        step(4); check("R11 same cycle pulse and drop", {30'h0, irq_out[5:4]}, 32'h1);
        step(1); check("R11 after pulse", {30'h0, irq_out[5:4]}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule